// File: doc/BRIEF.md
# Dual-Lane Fast Serial Frame Receiver

This block recovers frames sent by a matching serial transmitter over a clock line and one or two data lines. All three lines rest high when idle. The lines are sampled by a faster system clock through a synchronizer, and edges of the incoming clock are found by comparing successive samples. In normal mode every edge of the incoming clock carries a bit. Four edges with the data held high come before each frame and four come after it; none of them is shifted in. In the SPI-compatible mode only falling edges carry bits, and no such extra edges are sent.

A frame is a start nibble, a frame type nibble, a configurable number of data bytes, a CRC byte, a tag nibble and an end nibble. Every field arrives most significant bit first. When two lanes are enabled, the data and CRC bytes arrive two bits per edge: lane 1 carries the odd-numbered bits and lane 0 the even-numbered ones. The framing nibbles are then still read in full from lane 0 alone. At the end of a frame the fields are presented in parallel with a one-cycle valid pulse, or a one-cycle error pulse if the end nibble is wrong. The receiver then waits for a quiet period on the incoming clock before it looks for the next start nibble.

Top module: `fsr_rx`

## Requirements
- R1: After reset, frame_valid_o and frame_err_o are low and type_o, tag_o, crc_o and data_o are all zero.
- R2: In normal mode (spi_mode_i=0) one bit is taken on every edge of rx_clk_i, rising and falling. The four edges with data high before the start nibble are not taken as frame bits, and neither are the four after the end nibble.
- R3: The frame order is start nibble 4'b1001, type nibble, N data bytes with N = byte_cnt_m1_i+1, CRC byte, tag nibble, end nibble 4'b0110. Each field is MSB first. Byte k (k=0 first received) appears on data_o[8k+7:8k], and bytes at or beyond N read as zero.
- R4: With dual_lane_i=1, each edge of a data or CRC byte carries bit 2i+1 on rx_d1_i and bit 2i on rx_d0_i, for i from 3 down to 0. The nibble fields are taken from rx_d0_i only, and the value on rx_d1_i during them has no effect.
- R5: With spi_mode_i=1, bits are taken on falling edges of rx_clk_i only, and no preamble or postamble edges are expected.
- R6: An end nibble other than 4'b0110 gives a one-cycle frame_err_o pulse and no frame_valid_o. type_o, tag_o, crc_o and data_o keep their previous values.
- R7: After each end nibble the receiver ignores rx_clk_i until it has seen no edge for IDLE_CYC system cycles. A frame that begins before such a gap is not received.
- R8: frame_valid_o and frame_err_o are never high together, each is high for exactly one cycle per frame, and the parallel outputs change only in a cycle where frame_valid_o is high.
- R9: Data byte counts from 1 to MAX_BYTES (16 by default) are received correctly, including both limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_mode_i | input | 1 | 1: take bits on falling edges only; 0: take bits on both edges, with pre/postamble |
| dual_lane_i | input | 1 | 1: data and CRC bytes split over two lanes |
| byte_cnt_m1_i | input | IW (4) | Number of data bytes minus one |
| rx_clk_i | input | 1 | Incoming serial clock, idle high |
| rx_d0_i | input | 1 | Serial data lane 0, idle high |
| rx_d1_i | input | 1 | Serial data lane 1, idle high |
| frame_valid_o | output | 1 | One-cycle pulse when a frame ends correctly |
| frame_err_o | output | 1 | One-cycle pulse when the end nibble is wrong |
| type_o | output | 4 | Frame type of the last good frame |
| tag_o | output | 4 | Tag of the last good frame |
| crc_o | output | 8 | Received CRC byte of the last good frame |
| data_o | output | MAX_BYTES*8 (128) | Data bytes of the last good frame, byte 0 in the low bits |

## Verification
The assertions watch the output pulses on every cycle. They check that valid and error never coincide, that each lasts a single cycle, and that the parallel fields hold steady outside a valid pulse. Whether the bits are correct can only be shown by the bench's frames. Those frames cover lane interleaving, MSB-first order, skipping of preamble and postamble edges, falling-edge-only sampling, both byte-count limits, a corrupted end nibble, and a frame sent with no idle gap.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    ST_WAIT, ST_HUNT, ST_TYPE, ST_DATA, ST_CRC, ST_TAG, ST_END
  } rx_state_e;

  localparam logic [3:0] START_PAT = 4'b1001;
  localparam logic [3:0] END_PAT   = 4'b0110;
endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    // lines idle high, so reset high to avoid a false edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/fsr_edge.sv
module fsr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic spi_mode_i,
  input  logic sclk_i,
  output logic act_o,
  output logic stb_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sclk_i;
  end

  assign act_o = sclk_i ^ prev_q;
  assign stb_o = act_o & (~spi_mode_i | prev_q);
endmodule

// File: rtl/fsr_framer.sv
module fsr_framer
  import fsr_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 16,
  parameter int unsigned IDLE_CYC  = 16,
  localparam int unsigned IW = $clog2(MAX_BYTES),
  localparam int unsigned DW = MAX_BYTES * 8,
  localparam int unsigned CW = $clog2(IDLE_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          stb_i,
  input  logic          d0_i,
  input  logic          d1_i,
  input  logic          dual_i,
  input  logic [IW-1:0] nbytes_m1_i,
  output logic          valid_o,
  output logic          err_o,
  output logic [3:0]    type_o,
  output logic [3:0]    tag_o,
  output logic [7:0]    crc_o,
  output logic [DW-1:0] data_o
);
  rx_state_e     state_q;
  logic [3:0]    win_q, nib_q, type_q, tag_q;
  logic [7:0]    byte_sh_q, crc_q;
  logic [2:0]    cnt_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] idle_q;
  logic [7:0]    byte_q [MAX_BYTES];
  logic [DW-1:0] flat;

  logic [3:0] nxt_win, nxt_nib;
  logic [7:0] nxt_byte;
  logic       nib_done, byte_done;

  always_comb begin
    nxt_win   = {win_q[2:0], d0_i};
    nxt_nib   = {nib_q[2:0], d0_i};
    nxt_byte  = dual_i ? {byte_sh_q[5:0], d1_i, d0_i} : {byte_sh_q[6:0], d0_i};
    nib_done  = (cnt_q[1:0] == 2'd3);
    byte_done = dual_i ? (cnt_q == 3'd3) : (cnt_q == 3'd7);
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_pack
    assign flat[8*g +: 8] = byte_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_WAIT;
      win_q     <= '0;
      nib_q     <= '0;
      type_q    <= '0;
      tag_q     <= '0;
      crc_q     <= '0;
      byte_sh_q <= '0;
      cnt_q     <= '0;
      idx_q     <= '0;
      idle_q    <= '0;
      for (int i = 0; i < MAX_BYTES; i++) byte_q[i] <= '0;
      valid_o   <= 1'b0;
      err_o     <= 1'b0;
      type_o    <= '0;
      tag_o     <= '0;
      crc_o     <= '0;
      data_o    <= '0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      case (state_q)
        ST_WAIT: begin
          // postamble and any stray activity land here
          if (act_i) idle_q <= '0;
          else if (idle_q == CW'(IDLE_CYC - 1)) begin
            idle_q  <= '0;
            win_q   <= '0;
            state_q <= ST_HUNT;
          end else idle_q <= idle_q + 1'b1;
        end
        ST_HUNT: if (stb_i) begin
          win_q <= nxt_win;
          if (nxt_win == START_PAT) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            for (int i = 0; i < MAX_BYTES; i++) byte_q[i] <= '0;
            state_q <= ST_TYPE;
          end
        end
        ST_TYPE: if (stb_i) begin
          nib_q <= nxt_nib;
          cnt_q <= cnt_q + 1'b1;
          if (nib_done) begin
            type_q  <= nxt_nib;
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (stb_i) begin
          byte_sh_q <= nxt_byte;
          cnt_q     <= cnt_q + 1'b1;
          if (byte_done) begin
            byte_q[idx_q] <= nxt_byte;
            cnt_q         <= '0;
            if (idx_q == nbytes_m1_i) state_q <= ST_CRC;
            else                      idx_q   <= idx_q + 1'b1;
          end
        end
        ST_CRC: if (stb_i) begin
          byte_sh_q <= nxt_byte;
          cnt_q     <= cnt_q + 1'b1;
          if (byte_done) begin
            crc_q   <= nxt_byte;
            cnt_q   <= '0;
            state_q <= ST_TAG;
          end
        end
        ST_TAG: if (stb_i) begin
          nib_q <= nxt_nib;
          cnt_q <= cnt_q + 1'b1;
          if (nib_done) begin
            tag_q   <= nxt_nib;
            cnt_q   <= '0;
            state_q <= ST_END;
          end
        end
        ST_END: if (stb_i) begin
          nib_q <= nxt_nib;
          cnt_q <= cnt_q + 1'b1;
          if (nib_done) begin
            cnt_q   <= '0;
            idle_q  <= '0;
            state_q <= ST_WAIT;
            if (nxt_nib == END_PAT) begin
              valid_o <= 1'b1;
              type_o  <= type_q;
              tag_o   <= tag_q;
              crc_o   <= crc_q;
              data_o  <= flat;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/fsr_rx.sv
module fsr_rx #(
  parameter int unsigned MAX_BYTES   = 16,
  parameter int unsigned IDLE_CYC    = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IW = $clog2(MAX_BYTES),
  localparam int unsigned DW = MAX_BYTES * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          spi_mode_i,
  input  logic          dual_lane_i,
  input  logic [IW-1:0] byte_cnt_m1_i,
  input  logic          rx_clk_i,
  input  logic          rx_d0_i,
  input  logic          rx_d1_i,
  output logic          frame_valid_o,
  output logic          frame_err_o,
  output logic [3:0]    type_o,
  output logic [3:0]    tag_o,
  output logic [7:0]    crc_o,
  output logic [DW-1:0] data_o
);
  logic [2:0] sync_q;
  logic       act, stb;

  fsr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rx_d1_i, rx_d0_i, rx_clk_i}),
    .q_o   (sync_q)
  );

  fsr_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .spi_mode_i(spi_mode_i),
    .sclk_i    (sync_q[0]),
    .act_o     (act),
    .stb_o     (stb)
  );

  fsr_framer #(.MAX_BYTES(MAX_BYTES), .IDLE_CYC(IDLE_CYC)) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .stb_i      (stb),
    .d0_i       (sync_q[1]),
    .d1_i       (sync_q[2]),
    .dual_i     (dual_lane_i),
    .nbytes_m1_i(byte_cnt_m1_i),
    .valid_o    (frame_valid_o),
    .err_o      (frame_err_o),
    .type_o     (type_o),
    .tag_o      (tag_o),
    .crc_o      (crc_o),
    .data_o     (data_o)
  );
endmodule

// File: rtl/fsr_rx_chk.sv
module fsr_rx_chk #(
  parameter int unsigned DW = 128
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_valid_o,
  input logic          frame_err_o,
  input logic [3:0]    type_o,
  input logic [3:0]    tag_o,
  input logic [7:0]    crc_o,
  input logic [DW-1:0] data_o
);
  // R8
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_valid_o && frame_err_o));

  // R8
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o && !frame_err_o);

  // R6
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o && !frame_valid_o);

  // R6
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_o |-> $stable(type_o) && $stable(tag_o) && $stable(crc_o) && $stable(data_o));
endmodule

bind fsr_rx fsr_rx_chk #(.DW(MAX_BYTES * 8)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_valid_o(frame_valid_o),
  .frame_err_o  (frame_err_o),
  .type_o       (type_o),
  .tag_o        (tag_o),
  .crc_o        (crc_o),
  .data_o       (data_o)
);

// File: tb/tb_fsr_rx.sv
module tb_fsr_rx;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;
  localparam int DW = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_spi = 1'b0, cfg_dual = 1'b0;
  logic [3:0]    cfg_nm1 = '0;
  logic          rx_clk = 1'b1, rx_d0 = 1'b1, rx_d1 = 1'b1;
  logic          frame_valid, frame_err;
  logic [3:0]    type_w, tag_w;
  logic [7:0]    crc_w;
  logic [DW-1:0] data_w;

  int n_chk = 0, n_err = 0, n_val = 0, n_bad = 0;
  logic [7:0] tx_bytes [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  fsr_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .spi_mode_i(cfg_spi), .dual_lane_i(cfg_dual),
    .byte_cnt_m1_i(cfg_nm1), .rx_clk_i(rx_clk), .rx_d0_i(rx_d0), .rx_d1_i(rx_d1),
    .frame_valid_o(frame_valid), .frame_err_o(frame_err), .type_o(type_w),
    .tag_o(tag_w), .crc_o(crc_w), .data_o(data_w)
  );

  always @(negedge clk) begin
    if (frame_valid) n_val++;
    if (frame_err)   n_bad++;
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_data(input logic [3:0] nm1);
    logic [DW-1:0] v = '0;
    for (int k = 0; k < NB; k++) if (k <= int'(nm1)) v[8*k +: 8] = tx_bytes[k];
    return v;
  endfunction

  task automatic send_bit(input logic a0, input logic a1);
    rx_d0 = a0; rx_d1 = a1;
    repeat (2) @(negedge clk);
    if (cfg_spi) begin
      rx_clk = 1'b0;
      repeat (2) @(negedge clk);
      rx_clk = 1'b1;
      @(negedge clk);
    end else begin
      rx_clk = ~rx_clk;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic send_nib(input logic [3:0] v, input bit garb);
    for (int i = 3; i >= 0; i--) send_bit(v[i], garb ? ~v[i] : v[i]);
  endtask

  task automatic send_byte(input logic [7:0] b);
    if (cfg_dual) for (int i = 3; i >= 0; i--) send_bit(b[2*i], b[2*i+1]);
    else          for (int i = 7; i >= 0; i--) send_bit(b[i], 1'b1);
  endtask

  task automatic send_frame(input logic [3:0] ty, input logic [3:0] tg, input logic [7:0] cr,
                            input logic [3:0] eof, input bit garb, input bit gap);
    if (!cfg_spi) repeat (4) send_bit(1'b1, 1'b1);
    send_nib(4'b1001, garb);
    send_nib(ty, garb);
    for (int k = 0; k <= int'(cfg_nm1); k++) send_byte(tx_bytes[k]);
    send_byte(cr);
    send_nib(tg, garb);
    send_nib(eof, garb);
    if (!cfg_spi) repeat (4) send_bit(1'b1, 1'b1);
    rx_d0 = 1'b1; rx_d1 = 1'b1;
    if (gap) repeat (40) @(negedge clk);
  endtask

  task automatic fill_bytes();
    for (int k = 0; k < NB; k++) tx_bytes[k] = 8'($urandom);
  endtask

  task automatic good_frame(input string req, input logic [3:0] ty, input logic [3:0] tg,
                            input logic [7:0] cr, input bit garb);
    int v0 = n_val, b0 = n_bad;
    send_frame(ty, tg, cr, 4'b0110, garb, 1'b1);
    chk(n_val == v0 + 1, {req, " valid count"}, DW'(n_val), DW'(v0 + 1));
    chk(n_bad == b0, {req, " err count"}, DW'(n_bad), DW'(b0));
    chk(type_w == ty, {req, " type"}, DW'(type_w), DW'(ty));
    chk(tag_w == tg, {req, " tag"}, DW'(tag_w), DW'(tg));
    chk(crc_w == cr, {req, " crc"}, DW'(crc_w), DW'(cr));
    chk(data_w == exp_data(cfg_nm1), {req, " data"}, data_w, exp_data(cfg_nm1));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] keep_data;
    logic [3:0] keep_type;
    int v0, b0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);

    // R1 reset state
    chk(!frame_valid && !frame_err, "R1 pulses idle", DW'({frame_valid, frame_err}), '0);
    chk({type_w, tag_w, crc_w} == '0, "R1 fields zero", DW'({type_w, tag_w, crc_w}), '0);
    chk(data_w == '0, "R1 data zero", data_w, '0);

    // R2 R9 normal single lane, max byte count
    cfg_spi = 0; cfg_dual = 0; cfg_nm1 = 4'd15; fill_bytes();
    good_frame("R9 max bytes R2", 4'hA, 4'h5, 8'hC3, 1'b0);
    // R3 R9 min byte count, upper bytes zero
    cfg_nm1 = 4'd0; fill_bytes();
    good_frame("R3 R9 one byte", 4'h3, 4'hC, 8'h81, 1'b0);
    // R4 dual lane, lane 1 garbage on nibble fields
    cfg_dual = 1; cfg_nm1 = 4'd4; fill_bytes();
    good_frame("R4 dual garbage", 4'h9, 4'h6, 8'h5A, 1'b1);
    cfg_nm1 = 4'd15; fill_bytes();
    good_frame("R4 R9 dual max", 4'hF, 4'h0, 8'hA5, 1'b0);
    // R5 falling edge only
    cfg_spi = 1; cfg_dual = 0; cfg_nm1 = 4'd2; fill_bytes();
    good_frame("R5 spi single", 4'h1, 4'hE, 8'h3C, 1'b0);
    cfg_dual = 1; cfg_nm1 = 4'd1; fill_bytes();
    good_frame("R5 spi dual", 4'h7, 4'h8, 8'hF0, 1'b1);

    // R6 bad end nibble
    keep_data = data_w; keep_type = type_w;
    v0 = n_val; b0 = n_bad;
    cfg_spi = 0; cfg_dual = 0; cfg_nm1 = 4'd3; fill_bytes();
    send_frame(4'h2, 4'h4, 8'h11, 4'b0100, 1'b0, 1'b1);
    chk(n_bad == b0 + 1, "R6 err pulse", DW'(n_bad), DW'(b0 + 1));
    chk(n_val == v0, "R6 no valid", DW'(n_val), DW'(v0));
    chk(type_w == keep_type, "R6 type held", DW'(type_w), DW'(keep_type));
    chk(data_w == keep_data, "R6 data held", data_w, keep_data);

    // R7 frame without an idle gap is dropped
    cfg_nm1 = 4'd1; fill_bytes();
    v0 = n_val;
    send_frame(4'h4, 4'h2, 8'h22, 4'b0110, 1'b0, 1'b0);
    send_frame(4'hB, 4'hD, 8'h33, 4'b0110, 1'b0, 1'b1);
    chk(n_val == v0 + 1, "R7 one of two", DW'(n_val), DW'(v0 + 1));
    chk(type_w == 4'h4, "R7 first kept", DW'(type_w), DW'(4'h4));
    good_frame("R7 after gap", 4'hD, 4'h1, 8'h44, 1'b0);

    // R2 R3 R4 R5 random mix
    for (int f = 0; f < 30; f++) begin
      cfg_spi = 1'($urandom); cfg_dual = 1'($urandom); cfg_nm1 = 4'($urandom);
      fill_bytes();
      good_frame("R2 R3 R4 R5 random", 4'($urandom), 4'($urandom), 8'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule